// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four reset requests of a small microcontroller into one system reset and remembers which request caused it. Two supply-monitor flags (each high while the supply sits at or below its threshold) drive the system reset straight away, with no clock needed. The first monitor holds the reset for a fixed number of low-speed oscillator cycles after the supply recovers. The second monitor releases as soon as its synchronized flag clears. A watchdog underflow strobe and a software request bit each produce a short reset of fixed length.

Each source is gated. The first monitor needs a non-volatile option bit and three enable bits. The option bit is captured during power-on reset, and software cannot change it afterwards. The second monitor and the watchdog each have one enable bit. A watchdog underflow that is not enabled as a reset comes out as an interrupt request instead. Every reset forces the CPU clock select to the slow divided clock. All state is clocked by the low-speed oscillator. Reset asserts asynchronously and releases on a clock edge.

Top module: `mcu_rst_ctrl`

## Requirements
- R1: With monitor-1 enabled, `sys_rst_o` goes high in the same instant that `mon1_low_i` rises, before any clock edge.
- R2: After `mon1_low_i` falls, `sys_rst_o` stays high through the 33rd rising clock edge and drops after the 34th: 2 synchronizer edges, then 32 counted edges. A new low interval during the count restarts the whole count from its end.
- R3: Monitor-1 is enabled only when the captured option bit is 0 and bits [2:0] of register 0 are all 1. Those bits reset to 3'b111.
- R4: The option bit is taken from `nvm_opt_i` during power-on reset (`rst_ni` low). Later changes on `nvm_opt_i` have no effect until the next power-on reset.
- R5: With register 0 bit 3 set, `mon2_low_i` high drives `sys_rst_o` high at once. After the flag falls, `sys_rst_o` drops after the 2nd rising edge. With bit 3 clear the flag is ignored.
- R6: With register 1 bit 0 set, a one-cycle `wdt_unf_i` pulse gives a reset that is high after the sampling edge and drops after the 16th edge following it. With bit 0 clear, no reset occurs and `wdt_irq_o` follows `wdt_unf_i`.
- R7: Writing register 1 with bit 1 set starts a software reset at the next edge that lasts 16 cycles. The request bit clears itself, so no second reset follows.
- R8: `clk_sel_o` reads 2'b11 (slow clock divided by 8) while any reset is active and after it ends. Otherwise it shows the value last written to register 2 bits [1:0].
- R9: `cause_o` is 0 after power-on reset. At every edge where requests are active, it loads the code of the highest-priority one: monitor-1 = 1, monitor-2 = 2, watchdog = 3, software = 4. It keeps that value after the reset ends. Any write to register 3 clears it, but a request at the same edge wins over the clear.
- R10: Register 0 and register 1 bit 0 return to their reset values (0: 4'b0111, 1: bit 0 = 0) on a monitor-1 reset. Watchdog, software and monitor-2 resets leave them unchanged.
- R11: Register writes are ignored while `sys_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| mon1_low_i | input | 1 | Monitor-1 comparator flag, asynchronous, high = supply low |
| mon2_low_i | input | 1 | Monitor-2 comparator flag, asynchronous, high = supply low |
| nvm_opt_i | input | 1 | Non-volatile option bit, 0 = monitor-1 reset allowed |
| wdt_unf_i | input | 1 | Watchdog underflow strobe, one cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 monitor enables, 1 watchdog/software, 2 clock select, 3 cause clear |
| reg_wdata_i | input | 4 | Register write data |
| sys_rst_o | output | 1 | System reset, active high |
| cause_o | output | 3 | Code of the last reset source |
| clk_sel_o | output | 2 | CPU clock select, 2'b11 = slow clock divided by 8 |
| wdt_irq_o | output | 1 | Watchdog interrupt request when the watchdog is not set to reset |

## Verification
Two pairs of functions can land on the same edge. The first pair is a software request and a watchdog underflow. The bench arranges this by driving the strobe on the edge right after the request write, and it expects cause code 3 and a single 16-cycle reset. The second pair is a cause-clear write and a new request. The bench drives the clear write and an enabled underflow together, and it expects the capture to win. A third overlap, both supply flags at once, is also driven, and it must report monitor-1.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_MON1 = 3'd1,
    CAUSE_MON2 = 3'd2,
    CAUSE_WDT  = 3'd3,
    CAUSE_SW   = 3'd4
  } cause_e;

  localparam int          ADDR_W      = 2;
  localparam int          DATA_W      = 4;
  localparam logic [1:0]  CLK_LS_DIV8 = 2'b11;

  localparam logic [ADDR_W-1:0] A_MON_EN = 2'd0;
  localparam logic [ADDR_W-1:0] A_WDT_SW = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLKSEL = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 2'd3;

  function automatic cause_e pick_cause(input logic m1, input logic m2,
                                        input logic wd, input logic sw);
    if (m1)      return CAUSE_MON1;
    else if (m2) return CAUSE_MON2;
    else if (wd) return CAUSE_WDT;
    else if (sw) return CAUSE_SW;
    else         return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rst_hold_cnt.sv
// Holds busy_o for CYCLES edges after the last edge that saw trig_i.
module rst_hold_cnt #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int            CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rst_cfg_regs.sv
module rst_cfg_regs import rst_ctrl_pkg::*; #(
  parameter logic [2:0] MON1_CTL_RST = 3'b111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              m1_rst_i,
  input  logic              sys_rst_i,
  input  logic              cause_set_i,
  input  logic [2:0]        cause_code_i,
  output logic [2:0]        mon1_ctl_o,
  output logic              mon2_en_o,
  output logic              wdt_en_o,
  output logic              sw_pend_o,
  output logic [1:0]        clk_sel_o,
  output logic [2:0]        cause_o
);
  logic [2:0] mon1_ctl_q;
  logic       mon2_en_q, wdt_en_q, sw_pend_q;
  logic [1:0] clk_sel_q;
  logic [2:0] cause_q;

  // enables: cleared by power-on and monitor-1 reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon1_ctl_q <= MON1_CTL_RST;
      mon2_en_q  <= 1'b0;
      wdt_en_q   <= 1'b0;
    end else if (m1_rst_i) begin
      mon1_ctl_q <= MON1_CTL_RST;
      mon2_en_q  <= 1'b0;
      wdt_en_q   <= 1'b0;
    end else if (we_i && addr_i == A_MON_EN) begin
      mon1_ctl_q <= wdata_i[2:0];
      mon2_en_q  <= wdata_i[3];
    end else if (we_i && addr_i == A_WDT_SW) begin
      wdt_en_q   <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       sw_pend_q <= 1'b0;
    else if (sw_pend_q)                                sw_pend_q <= 1'b0;
    else if (we_i && addr_i == A_WDT_SW && wdata_i[1]) sw_pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            clk_sel_q <= CLK_LS_DIV8;
    else if (sys_rst_i)                     clk_sel_q <= CLK_LS_DIV8;
    else if (we_i && addr_i == A_CLKSEL)    clk_sel_q <= wdata_i[1:0];
  end

  // capture beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cause_q <= CAUSE_NONE;
    else if (cause_set_i)                cause_q <= cause_code_i;
    else if (we_i && addr_i == A_CAUSE)  cause_q <= CAUSE_NONE;
  end

  assign mon1_ctl_o = mon1_ctl_q;
  assign mon2_en_o  = mon2_en_q;
  assign wdt_en_o   = wdt_en_q;
  assign sw_pend_o  = sw_pend_q;
  assign clk_sel_o  = clk_sel_q;
  assign cause_o    = cause_q;
endmodule

// File: rtl/mcu_rst_ctrl.sv
module mcu_rst_ctrl import rst_ctrl_pkg::*; #(
  parameter int         SYNC_STAGES      = 2,
  parameter int         MON1_RELEASE_CYC = 32,
  parameter int         SOFT_HOLD_CYC    = 16,
  parameter logic [2:0] MON1_CTL_RST     = 3'b111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mon1_low_i,
  input  logic              mon2_low_i,
  input  logic              nvm_opt_i,
  input  logic              wdt_unf_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              sys_rst_o,
  output logic [2:0]        cause_o,
  output logic [1:0]        clk_sel_o,
  output logic              wdt_irq_o
);
  logic       opt_q;
  logic [1:0] low_s;
  logic [2:0] mon1_ctl;
  logic       mon2_en_q, wdt_en, sw_pend;
  logic       m1_en, m2_en, m1_req_s, m2_req_s, wdt_req;
  logic       m1_busy, short_busy, any_req, we_ok;
  logic [1:0] clk_sel_q;
  cause_e     cause_d;

  // option bit loaded only while power-on reset holds
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) opt_q <= nvm_opt_i;

  rst_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mon2_low_i, mon1_low_i}),
    .q_o   (low_s)
  );

  assign m1_en    = ~opt_q & (&mon1_ctl);
  assign m2_en    = mon2_en_q;
  assign m1_req_s = m1_en & low_s[0];
  assign m2_req_s = m2_en & low_s[1];
  assign wdt_req  = wdt_unf_i & wdt_en;

  rst_hold_cnt #(.CYCLES(MON1_RELEASE_CYC)) u_m1_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(m1_req_s),
    .busy_o(m1_busy)
  );

  rst_hold_cnt #(.CYCLES(SOFT_HOLD_CYC)) u_soft_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(wdt_req | sw_pend),
    .busy_o(short_busy)
  );

  // raw flags assert at once; registered terms set the release edge
  assign sys_rst_o = ~rst_ni | (m1_en & mon1_low_i) | (m2_en & mon2_low_i)
                   | m1_req_s | m1_busy | m2_req_s | short_busy;

  assign we_ok   = reg_we_i & ~sys_rst_o;
  assign any_req = m1_req_s | m2_req_s | wdt_req | sw_pend;
  assign cause_d = pick_cause(m1_req_s, m2_req_s, wdt_req, sw_pend);

  rst_cfg_regs #(.MON1_CTL_RST(MON1_CTL_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_ok),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .m1_rst_i    (m1_req_s | m1_busy),
    .sys_rst_i   (sys_rst_o),
    .cause_set_i (any_req),
    .cause_code_i(cause_d),
    .mon1_ctl_o  (mon1_ctl),
    .mon2_en_o   (mon2_en_q),
    .wdt_en_o    (wdt_en),
    .sw_pend_o   (sw_pend),
    .clk_sel_o   (clk_sel_q),
    .cause_o     (cause_o)
  );

  assign clk_sel_o = sys_rst_o ? CLK_LS_DIV8 : clk_sel_q;
  assign wdt_irq_o = wdt_unf_i & ~wdt_en;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk import rst_ctrl_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_o,
  input logic              wdt_irq_o,
  input logic [2:0]        cause_o,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              m1_req_s,
  input logic              m2_req_s,
  input logic              m1_busy,
  input logic              short_busy,
  input logic              wdt_req,
  input logic              wdt_en,
  input logic              sw_pend,
  input logic              any_req,
  input logic [2:0]        mon1_ctl,
  input logic [1:0]        clk_sel_q
);
  a_r1_mon1_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m1_req_s |=> m1_busy && sys_rst_o);

  a_r2_no_early_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(m1_busy) |-> !m1_req_s && $past(!m1_req_s));

  a_r5_mon2_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m2_req_s |-> sys_rst_o);

  a_r6_wdt_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_req |=> short_busy && sys_rst_o);

  a_r6_irq_only_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_irq_o |-> !wdt_en);

  a_r7_sw_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pend |=> !sw_pend && short_busy);

  a_r8_clk_slow_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> clk_sel_q == CLK_LS_DIV8);

  a_r9_cause_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_req && !(reg_we_i && reg_addr_i == A_CAUSE && !sys_rst_o)) |=> $stable(cause_o));

  a_r10_enables_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_busy && !m1_req_s && !m1_busy) |=> $stable(mon1_ctl) && $stable(wdt_en));
endmodule

bind mcu_rst_ctrl rst_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_o (sys_rst_o),
  .wdt_irq_o (wdt_irq_o),
  .cause_o   (cause_o),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .m1_req_s  (m1_req_s),
  .m2_req_s  (m2_req_s),
  .m1_busy   (m1_busy),
  .short_busy(short_busy),
  .wdt_req   (wdt_req),
  .wdt_en    (wdt_en),
  .sw_pend   (sw_pend),
  .any_req   (any_req),
  .mon1_ctl  (mon1_ctl),
  .clk_sel_q (clk_sel_q)
);

// File: tb/tb_mcu_rst_ctrl.sv
module tb_mcu_rst_ctrl;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mon1_low_i = 1'b0, mon2_low_i = 1'b0, nvm_opt_i = 1'b0, wdt_unf_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [3:0] reg_wdata_i = '0;
  logic       sys_rst_o, wdt_irq_o;
  logic [2:0] cause_o;
  logic [1:0] clk_sel_o;

  int checks = 0;
  int errs   = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mcu_rst_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mon1_low_i(mon1_low_i), .mon2_low_i(mon2_low_i),
    .nvm_opt_i(nvm_opt_i), .wdt_unf_i(wdt_unf_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .sys_rst_o(sys_rst_o),
    .cause_o(cause_o), .clk_sel_o(clk_sel_o), .wdt_irq_o(wdt_irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic por(input logic opt);
    @(negedge clk_i);
    rst_ni = 1'b0; nvm_opt_i = opt;
    mon1_low_i = 1'b0; mon2_low_i = 1'b0; wdt_unf_i = 1'b0; reg_we_i = 1'b0;
    negs(2);
    rst_ni = 1'b1;
    negs(1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wdt_pulse;
    wdt_unf_i = 1'b1;
    @(negedge clk_i);
    wdt_unf_i = 1'b0;
  endtask

  initial begin
    // reset state (R8, R9)
    @(negedge clk_i);
    chk("R8 por sys_rst", 8'(sys_rst_o), 8'd1);
    chk("R8 por clk_sel", 8'(clk_sel_o), 8'd3);
    negs(1); rst_ni = 1'b1; negs(1);
    chk("R9 por cause", 8'(cause_o), 8'd0);
    chk("R8 idle sys_rst", 8'(sys_rst_o), 8'd0);
    chk("R8 idle clk_sel", 8'(clk_sel_o), 8'd3);
    wr(2'd2, 4'd0);
    chk("R8 clk_sel write", 8'(clk_sel_o), 8'd0);

    // R1/R3 sweep over option bit and enable bits
    for (int opt = 0; opt < 2; opt++) begin
      for (int ctl = 0; ctl < 8; ctl++) begin
        logic en;
        en = (opt == 0) && (ctl == 7);
        por(opt[0]);
        wr(2'd0, {1'b0, 3'(ctl)});
        mon1_low_i = 1'b1;
        #1;
        chk("R1 R3 mon1 assert", 8'(sys_rst_o), 8'(en));
        negs(4);
        chk("R3 mon1 cause", 8'(cause_o), en ? 8'd1 : 8'd0);
        mon1_low_i = 1'b0;
        negs(en ? 40 : 3);
        chk("R3 sweep released", 8'(sys_rst_o), 8'd0);
      end
    end

    // R2 release count and restart
    por(1'b0);
    wr(2'd2, 4'd1);
    mon1_low_i = 1'b1; negs(5);
    chk("R8 clk_sel in reset", 8'(clk_sel_o), 8'd3);
    mon1_low_i = 1'b0;
    for (int i = 1; i <= 34; i++) begin
      @(negedge clk_i);
      if (i == 33) chk("R2 held edge 33", 8'(sys_rst_o), 8'd1);
      if (i == 34) chk("R2 released edge 34", 8'(sys_rst_o), 8'd0);
    end
    chk("R9 mon1 cause kept", 8'(cause_o), 8'd1);
    chk("R8 clk_sel after mon1", 8'(clk_sel_o), 8'd3);
    mon1_low_i = 1'b1; negs(3); mon1_low_i = 1'b0;
    negs(20);
    mon1_low_i = 1'b1; negs(3); mon1_low_i = 1'b0;   // dip mid-count
    for (int i = 1; i <= 34; i++) begin
      @(negedge clk_i);
      if (i == 33) chk("R2 restart held", 8'(sys_rst_o), 8'd1);
      if (i == 34) chk("R2 restart released", 8'(sys_rst_o), 8'd0);
    end

    // R4 option bit frozen after power-on
    por(1'b0);
    nvm_opt_i = 1'b1; negs(3);
    mon1_low_i = 1'b1; #1;
    chk("R4 late opt=1 ignored", 8'(sys_rst_o), 8'd1);
    negs(2); mon1_low_i = 1'b0; negs(40);
    por(1'b1);
    nvm_opt_i = 1'b0; negs(3);
    mon1_low_i = 1'b1; #1;
    chk("R4 late opt=0 ignored", 8'(sys_rst_o), 8'd0);
    negs(3); mon1_low_i = 1'b0; negs(3);

    // R5 monitor-2
    por(1'b0);
    mon2_low_i = 1'b1; #1;
    chk("R5 mon2 disabled", 8'(sys_rst_o), 8'd0);
    negs(3); mon2_low_i = 1'b0; negs(3);
    wr(2'd0, 4'b1111);
    mon2_low_i = 1'b1; #1;
    chk("R5 mon2 assert", 8'(sys_rst_o), 8'd1);
    negs(3);
    chk("R9 mon2 cause", 8'(cause_o), 8'd2);
    mon2_low_i = 1'b0;
    negs(1);
    chk("R5 mon2 held edge 1", 8'(sys_rst_o), 8'd1);
    negs(1);
    chk("R5 mon2 released edge 2", 8'(sys_rst_o), 8'd0);
    // both monitors together: priority
    mon1_low_i = 1'b1; mon2_low_i = 1'b1; negs(5);
    chk("R9 mon1 over mon2", 8'(cause_o), 8'd1);
    mon1_low_i = 1'b0; mon2_low_i = 1'b0; negs(40);

    // R6 watchdog
    por(1'b0);
    wdt_unf_i = 1'b1; #1;
    chk("R6 irq when unarmed", 8'(wdt_irq_o), 8'd1);
    @(negedge clk_i); wdt_unf_i = 1'b0;
    chk("R6 no reset unarmed", 8'(sys_rst_o), 8'd0);
    wr(2'd1, 4'b0001);
    wr(2'd2, 4'd2);
    wdt_unf_i = 1'b1; #1;
    chk("R6 no irq armed", 8'(wdt_irq_o), 8'd0);
    @(negedge clk_i); wdt_unf_i = 1'b0;
    chk("R6 wdt reset on", 8'(sys_rst_o), 8'd1);
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk_i);
      if (i == 15) chk("R6 wdt held 15", 8'(sys_rst_o), 8'd1);
      if (i == 16) chk("R6 wdt released 16", 8'(sys_rst_o), 8'd0);
    end
    chk("R9 wdt cause", 8'(cause_o), 8'd3);
    chk("R8 clk_sel after wdt", 8'(clk_sel_o), 8'd3);
    wdt_pulse();
    chk("R10 wdt enable kept", 8'(sys_rst_o), 8'd1);
    negs(20);

    // R7 software reset
    wr(2'd3, 4'd0);
    chk("R9 cause cleared", 8'(cause_o), 8'd0);
    wr(2'd1, 4'b0010);
    chk("R7 not yet", 8'(sys_rst_o), 8'd0);
    for (int i = 1; i <= 17; i++) begin
      @(negedge clk_i);
      if (i == 1)  chk("R7 sw start", 8'(sys_rst_o), 8'd1);
      if (i == 16) chk("R7 sw held 16", 8'(sys_rst_o), 8'd1);
      if (i == 17) chk("R7 sw released 17", 8'(sys_rst_o), 8'd0);
    end
    chk("R9 sw cause", 8'(cause_o), 8'd4);
    negs(20);
    chk("R7 no second reset", 8'(sys_rst_o), 8'd0);

    // R11 writes during reset ignored
    wr(2'd2, 4'd1);
    wr(2'd1, 4'b0010);
    negs(1);
    wr(2'd2, 4'd0);
    wr(2'd3, 4'd0);
    wr(2'd0, 4'b0000);
    negs(20);
    chk("R11 clk_sel write ignored", 8'(clk_sel_o), 8'd3);
    chk("R11 cause clear ignored", 8'(cause_o), 8'd4);
    mon1_low_i = 1'b1; #1;
    chk("R11 enable write ignored", 8'(sys_rst_o), 8'd1);
    negs(2); mon1_low_i = 1'b0; negs(40);

    // R9 simultaneous sw + wdt, and clear vs capture
    wr(2'd1, 4'b0001);
    wr(2'd1, 4'b0011);
    wdt_unf_i = 1'b1;
    @(negedge clk_i); wdt_unf_i = 1'b0;
    chk("R9 wdt over sw", 8'(cause_o), 8'd3);
    for (int i = 2; i <= 17; i++) begin
      @(negedge clk_i);
      if (i == 16) chk("R9 joint held", 8'(sys_rst_o), 8'd1);
      if (i == 17) chk("R9 joint released", 8'(sys_rst_o), 8'd0);
    end
    negs(20);
    wr(2'd1, 4'b0010);
    negs(20);
    chk("R9 sw cause set", 8'(cause_o), 8'd4);
    wr(2'd1, 4'b0001);
    reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 4'd0; wdt_unf_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; wdt_unf_i = 1'b0;
    chk("R9 capture beats clear", 8'(cause_o), 8'd3);
    negs(20);

    // R10 enables survive sw reset, restored by monitor-1 reset
    por(1'b0);
    wr(2'd0, 4'b1000);
    wr(2'd1, 4'b0011);
    negs(20);
    mon1_low_i = 1'b1; #1;
    chk("R10 mon1 stays off", 8'(sys_rst_o), 8'd0);
    negs(3); mon1_low_i = 1'b0; negs(3);
    mon2_low_i = 1'b1; #1;
    chk("R10 mon2 stays on", 8'(sys_rst_o), 8'd1);
    negs(3); mon2_low_i = 1'b0; negs(3);
    wr(2'd0, 4'b1111);
    mon1_low_i = 1'b1; negs(4); mon1_low_i = 1'b0; negs(40);
    mon2_low_i = 1'b1; #1;
    chk("R10 mon2 restored off", 8'(sys_rst_o), 8'd0);
    negs(3); mon2_low_i = 1'b0; negs(3);
    wdt_unf_i = 1'b1; #1;
    chk("R10 wdt restored off", 8'(wdt_irq_o), 8'd1);
    @(negedge clk_i); wdt_unf_i = 1'b0;
    chk("R10 no wdt reset", 8'(sys_rst_o), 8'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule